// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Nine-Level DAC

This block sits between a nine-level quantizer and a DAC made of eight equal unit elements. Each clock it takes a level code from 0 to 8 and raises exactly that many element enables. The choice of *which* elements to enable sets how element mismatch shows up in the output. In the rotating modes, a pointer walks around the ring of elements. Each element is therefore driven by a sequence whose mismatch error is shaped away from the band of interest, instead of being left white.

There are three ways of working. In thermometer mode the lowest-indexed elements are always used, which gives an unshaped baseline for comparison. In rotate mode one pointer picks the first element of each group and then moves past the last element used. In two-path mode two independent pointers take turns on alternate samples. This interleaved form suits a loop whose noise zeros sit at a quarter of the sample rate.

The two-path alternation is held by a small state machine with two states:
- **ST_PATH_A** (the reset state): the next two-path sample uses pointer A. A two-path sample moves it to ST_PATH_B. Any other mode keeps it in ST_PATH_A.
- **ST_PATH_B**: the next two-path sample uses pointer B. From here every sample returns it to ST_PATH_A.

Top module: `dem_rotate_sel`

## Requirements
- R1: While reset is asserted, all enables are low. After reset both pointers are 0, and the state machine is in ST_PATH_A.
- R2: `elem_en` is registered. After each rising edge it reflects the `code_in` and `mode_in` sampled at that edge. For codes 0 to 8, the number of enables that are high equals the code.
- R3: In rotate mode (`mode_in` = 2'b01) with code c, the enabled elements are the c consecutive indices that start at pointer A. The group wraps from index 7 to index 0.
- R4: In rotate mode, pointer A advances by c modulo 8 on every sample, so the next group starts just after the last element used.
- R5: In thermometer mode (`mode_in` = 2'b00) with code c, the enabled elements are indices 0 to c-1.
- R6: Codes 9 to 15 act as 8. All eight enables are high, and the pointer in use advances by 8, which leaves it unchanged.
- R7: In two-path mode (`mode_in` = 2'b10), samples alternate between paths. The first sample after reset, or after any other mode, uses pointer A. The next uses pointer B, and so on. The group starts at the active pointer, and only the active pointer advances.
- R8: With a constant code c in rotate mode, every run of 8 consecutive samples uses each element exactly c times.
- R9: Thermometer mode and the spare mode (2'b11) leave both pointers unchanged, and the spare mode selects as thermometer mode does. Rotate mode leaves pointer B unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 4 | Quantizer level, 0 to 8 (larger values act as 8) |
| mode_in | input | 2 | 00 thermometer, 01 rotate, 10 two-path, 11 spare (as thermometer) |
| elem_en | output | 8 | Registered unit-element enables, bit i drives element i |

## Verification
The bench drives groups that cross the wrap from element 7 back to 0. A design with a wrong modulo would drop or duplicate enables there. It also sends codes of 0 and 8, and out-of-range codes. Such codes expose a pointer that moves on a full group, or a popcount that overflows past eight.

In two-path mode the bench checks that pointer B stays frozen while rotate mode runs. It also checks that returning to two-path mode restarts on path A. A swapped or shared pointer would start groups at the wrong index. Thermometer detours must resume rotation exactly where it stopped.

A long constant-code run counts per-element usage over each eight-sample window. This catches a pointer that advances by the wrong amount, because such a pointer would leave the usage uneven.

// File: rtl/erot_pkg.sv
package erot_pkg;

    typedef enum logic [1:0] {
        MODE_THERM   = 2'd0,
        MODE_ROTATE  = 2'd1,
        MODE_TWOPATH = 2'd2,
        MODE_SPARE   = 2'd3
    } dem_mode_e;

    typedef enum logic {
        ST_PATH_A = 1'b0,
        ST_PATH_B = 1'b1
    } path_state_e;

endpackage

// File: rtl/erot_therm.sv
module erot_therm #(
    parameter int N_ELEM = 8,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_ELEM-1:0] therm
);
    // Bit i is set when the level exceeds i; codes above N_ELEM saturate.
    for (genvar gi = 0; gi < N_ELEM; gi++) begin : g_bit
        assign therm[gi] = (code > CODE_W'(gi));
    end
endmodule

// File: rtl/erot_rotl.sv
module erot_rotl #(
    parameter int N_ELEM = 8,
    parameter int PTR_W  = 3
) (
    input  logic [N_ELEM-1:0] din,
    input  logic [PTR_W-1:0]  shift,
    output logic [N_ELEM-1:0] dout
);
    // Ring rotation toward higher indices; N_ELEM is a power of two, so
    // the index arithmetic wraps on its own.
    for (genvar gj = 0; gj < N_ELEM; gj++) begin : g_out
        assign dout[gj] = din[PTR_W'(gj) - shift];
    end
endmodule

// File: rtl/erot_ptr.sv
module erot_ptr #(
    parameter int N_PATH = 2,
    parameter int PTR_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PATH-1:0]             adv,
    input  logic [PTR_W-1:0]              step,
    output logic [N_PATH-1:0][PTR_W-1:0]  ptr
);
    for (genvar gp = 0; gp < N_PATH; gp++) begin : g_path
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr[gp] <= '0;
            end else if (adv[gp]) begin
                ptr[gp] <= ptr[gp] + step;
            end
        end

        // R9: a pointer whose path was idle keeps its value
        assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(adv[gp])) |-> $stable(ptr[gp]));
    end

    // R7: at most one path moves per sample
    assert_one_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adv));
endmodule

// File: rtl/dem_rotate_sel.sv
module dem_rotate_sel
    import erot_pkg::*;
#(
    parameter int  N_ELEM = 8,
    localparam int CODE_W = $clog2(N_ELEM + 1),
    localparam int PTR_W  = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic [1:0]        mode_in,
    output logic [N_ELEM-1:0] elem_en
);
    localparam int N_PATH = 2;

    dem_mode_e                    mode;
    path_state_e                  state_q, state_d;
    logic [PTR_W-1:0]             step;
    logic [PTR_W-1:0]             shift;
    logic [N_PATH-1:0]            adv;
    logic [N_PATH-1:0][PTR_W-1:0] ptr;
    logic [N_ELEM-1:0]            therm;
    logic [N_ELEM-1:0]            rot_out;

    assign mode = dem_mode_e'(mode_in);

    // Advance per sample: code modulo N_ELEM, with a full group moving by zero.
    assign step = (code_in >= CODE_W'(N_ELEM)) ? '0 : code_in[PTR_W-1:0];

    // Path state machine: next state
    always_comb begin
        state_d = ST_PATH_A;
        unique case (state_q)
            ST_PATH_A: state_d = (mode == MODE_TWOPATH) ? ST_PATH_B : ST_PATH_A;
            ST_PATH_B: state_d = ST_PATH_A;
            default:   state_d = ST_PATH_A;
        endcase
    end

    // Pointer selection and advance enables
    always_comb begin
        adv   = '0;
        shift = '0;
        unique case (mode)
            MODE_ROTATE: begin
                adv[0] = 1'b1;
                shift  = ptr[0];
            end
            MODE_TWOPATH: begin
                if (state_q == ST_PATH_B) begin
                    adv[1] = 1'b1;
                    shift  = ptr[1];
                end else begin
                    adv[0] = 1'b1;
                    shift  = ptr[0];
                end
            end
            MODE_THERM, MODE_SPARE: begin
                adv   = '0;
                shift = '0;
            end
            default: ;
        endcase
    end

    erot_ptr #(.N_PATH(N_PATH), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .step  (step),
        .ptr   (ptr)
    );

    erot_therm #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_therm (
        .code  (code_in),
        .therm (therm)
    );

    erot_rotl #(.N_ELEM(N_ELEM), .PTR_W(PTR_W)) u_rotl (
        .din   (therm),
        .shift (shift),
        .dout  (rot_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PATH_A;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elem_en <= '0;
        else        elem_en <= rot_out;
    end

    // R1: held low throughout reset
    always_comb begin
        if (!rst_n) assert_reset_low_R1: assert (elem_en == '0);
    end

    // R2 / R6: enable count follows the saturated level
    assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ($countones(elem_en) ==
         (($past(code_in) > CODE_W'(N_ELEM)) ? N_ELEM : int'($past(code_in)))));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(code_in) >= CODE_W'(N_ELEM))) |-> (&elem_en));

    // R3: a rotate group begins at the pointer
    assert_rot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == MODE_ROTATE) && ($past(code_in) != '0))
        |-> elem_en[$past(ptr[0])]);

    // R5: thermometer groups are contiguous from index 0
    assert_therm_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == MODE_THERM))
        |-> (((elem_en + N_ELEM'(1)) & elem_en) == '0));

    // R7: two-path samples alternate the path state
    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == MODE_TWOPATH)) |-> (state_q != $past(state_q)));

    assert_pathb_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == MODE_TWOPATH) &&
         ($past(state_q) == ST_PATH_B) && ($past(code_in) != '0))
        |-> elem_en[$past(ptr[1])]);
endmodule

// File: tb/sim_dem_rotate_sel.sv
`timescale 1ns/1ps
module sim_dem_rotate_sel;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] code_in;
    logic [1:0] mode_in;
    logic [7:0] elem_en;

    int n_chk  = 0;
    int n_fail = 0;
    int m_pa   = 0;
    int m_pb   = 0;
    int m_ph   = 0;
    int use_cnt [8];

    always #2.5 clk = ~clk;

    dem_rotate_sel u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (code_in),
        .mode_in (mode_in),
        .elem_en (elem_en)
    );

    function automatic logic [7:0] win(int start, int cnt);
        logic [7:0] w = '0;
        for (int i = 0; i < cnt; i++) w[(start + i) % 8] = 1'b1;
        return w;
    endfunction

    task automatic check_vec(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample, predict from the requirements, check after the edge.
    task automatic sample(int c, logic [1:0] m, string req);
        int cs = (c > 8) ? 8 : c;
        logic [7:0] exp;
        case (m)
            2'b01: begin exp = win(m_pa, cs); m_pa = (m_pa + cs) % 8; m_ph = 0; end
            2'b10: begin
                if (m_ph == 0) begin exp = win(m_pa, cs); m_pa = (m_pa + cs) % 8; end
                else           begin exp = win(m_pb, cs); m_pb = (m_pb + cs) % 8; end
                m_ph = 1 - m_ph;
            end
            default: begin exp = win(0, cs); m_ph = 0; end
        endcase
        code_in = 4'(c);
        mode_in = m;
        @(negedge clk);
        check_vec(req, elem_en, exp);
        check_int({req, " count"}, $countones(elem_en), cs);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; code_in = 4'd5; mode_in = 2'b01;
        repeat (3) @(negedge clk);
        check_vec("R1 reset", elem_en, 8'h00);
        rst_n = 1'b1;
        sample(3, 2'b01, "R1 first group from index 0");
    endtask

    task automatic t_therm;
        for (int c = 0; c <= 8; c++) sample(c, 2'b00, "R5 thermometer");
        sample(0, 2'b11, "R9 spare as thermometer");
        sample(6, 2'b11, "R9 spare as thermometer");
    endtask

    task automatic t_rotate;
        sample(2, 2'b01, "R3 rotate");
        sample(5, 2'b01, "R3 R4 rotate wrap");
        sample(0, 2'b01, "R2 zero code");
        sample(7, 2'b01, "R4 rotate wrap");
        sample(8, 2'b01, "R2 full code");
        sample(1, 2'b01, "R4 after full");
    endtask

    task automatic t_saturate;
        sample(12, 2'b01, "R6 code 12 rotate");
        sample(15, 2'b00, "R6 code 15 thermometer");
        sample(9,  2'b10, "R6 code 9 two-path");
        sample(3,  2'b01, "R6 pointer unchanged");
    endtask

    task automatic t_ignore;
        sample(5, 2'b00, "R9 thermometer detour");
        sample(8, 2'b00, "R9 thermometer detour");
        sample(4, 2'b11, "R9 spare detour");
        sample(2, 2'b01, "R9 rotate resumes");
    endtask

    task automatic t_twopath;
        sample(3, 2'b10, "R7 path A");
        sample(5, 2'b10, "R7 path B");
        sample(6, 2'b10, "R7 path A");
        sample(4, 2'b10, "R7 path B");
        sample(1, 2'b01, "R9 rotate leaves B");
        sample(2, 2'b10, "R7 restart on A");
        sample(7, 2'b10, "R7 path B kept");
        sample(0, 2'b10, "R7 zero on A");
        sample(8, 2'b10, "R7 full on B");
    endtask

    task automatic t_balance;
        for (int c = 1; c <= 7; c += 2) begin
            for (int w = 0; w < 8; w++) begin
                for (int k = 0; k < 8; k++) use_cnt[k] = 0;
                for (int s = 0; s < 8; s++) begin
                    sample(c, 2'b01, "R8 balance run");
                    for (int k = 0; k < 8; k++) use_cnt[k] += int'(elem_en[k]);
                end
                for (int k = 0; k < 8; k++) check_int("R8 per-element usage", use_cnt[k], c);
            end
        end
    endtask

    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; code_in = '0; mode_in = '0;
        @(negedge clk);
        t_reset;
        t_therm;
        t_rotate;
        t_saturate;
        t_ignore;
        t_twopath;
        t_balance;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule